// File: doc/BRIEF.md
# Sector Transfer Setup Checker

This block sits between a disk controller's command decoder and its DMA engine. When a READ or WRITE command has collected its arguments, the block receives them together with the geometry of the selected drive and a write-protect flag. It checks the requested position against that geometry and works out where the transfer starts and how many bytes it moves. It then either hands a transfer request to the DMA engine or ends the command at once with an error completion. The DMA engine and the media are outside the block. A pair of outcome inputs, `xfer_done` and `xfer_err`, reports how the transfer ended. Every completion produces a one-cycle `done` pulse for the interrupt logic and seven result bytes.

The block records the last cylinder reached by each drive, so it can tell whether a command moved the head. The gap-length argument has no effect on the transfer, so it is not an input. Of the drive-select argument, only the bits that select a drive are taken.

Top module: `sector_xfer_setup`

## Requirements
- R1: After reset, `done` and `xfer_req` are 0, `res_bytes` is all zero, and every drive's recorded cylinder is 0.
- R2: A sector of 0 or above `geo_spt` ends the command with no request. Result byte 0 is 0x40 | head[0]<<2 | drive, and result byte 1 is 0. The sector check takes priority over the cylinder/head check.
- R3: A cylinder ≥ `geo_cyls` or a head ≥ `geo_heads`, with a valid sector, ends the command with byte 0 = 0x40 | head[0]<<2 | drive and byte 1 = 0x80. The recorded cylinder does not change.
- R4: The size code is clamped to 7. For code 0 (128-byte sectors) the transfer length is min(data-length, 128).
- R5: For codes 1 to 7, length = n × (128 << code), where n = end-of-track − sector + 1. With `cmd_mt` set, n = 2 × end-of-track − sector + 1.
- R6: For codes 1 to 7, an n of 0 or below ends the command with byte 0 bit 6 set and byte 1 = 0x01.
- R7: A write (`cmd_write`=1) with `wr_prot`=1 and no earlier fault ends with byte 0 = 0x60 | head[0]<<2 | drive and byte 1 = 0x02. A read ignores `wr_prot`.
- R8: The transfer offset is ((cylinder × heads + head) × spt + sector − 1) × (128 << code).
- R9: A command that passes the geometry checks stores its cylinder as the drive's recorded cylinder. If that cylinder differs from the previously recorded one, byte 0 bit 5 is set in the command's completion.
- R10: On `xfer_done`, the completion has byte 0 = bit5 | head[0]<<2 | drive, bytes 1 and 2 = 0, and bytes 3–5 = the next sector's cylinder, head and sector. The next sector is sector+1. At the sector equal to spt it wraps to 1: with multi-track, head 0 and two or more heads, the head becomes 1; otherwise the cylinder increments, and with multi-track the head becomes 0. Byte 6 is the raw size code.
- R11: On `xfer_err` (taking priority over `xfer_done`), byte 0 = 0x40 | bit5 | head[0]<<2 | drive and byte 1 = 0. Bytes 3, 4 and 5 of every error completion carry the requested cylinder, head and sector. Result byte i is `res_bytes[8i+7:8i]`.
- R12: `xfer_req` rises, or an error `done` pulses, in the second cycle after `cmd_valid`. `done` pulses one cycle after an outcome. `done` is a one-cycle pulse. `cmd_valid` has no effect while a command is pending, and outcome inputs have no effect when no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Arguments are valid (one cycle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_mt | input | 1 | Multi-track flag |
| arg_drive | input | DSW | Drive select |
| arg_cyl | input | 8 | Requested cylinder |
| arg_head | input | 8 | Requested head |
| arg_sect | input | 8 | Requested first sector (1-based) |
| arg_size | input | 8 | Sector size code |
| arg_eot | input | 8 | Last sector number of the track |
| arg_dtl | input | 8 | Data length for 128-byte sectors |
| geo_cyls | input | 8 | Cylinder count of the drive |
| geo_heads | input | 8 | Head count of the drive |
| geo_spt | input | 8 | Sectors per track |
| wr_prot | input | 1 | Selected medium is write-protected |
| xfer_req | output | 1 | Transfer request to the DMA engine, held until an outcome |
| xfer_write | output | 1 | Direction of the requested transfer |
| xfer_ofs | output | OFS_W | Byte offset of the transfer |
| xfer_len | output | LEN_W | Byte length of the transfer |
| xfer_done | input | 1 | Transfer finished without error |
| xfer_err | input | 1 | Transfer failed |
| done | output | 1 | Completion pulse |
| res_bytes | output | 56 | Seven result bytes, byte i at bits 8i+7:8i |

## Verification
Two functions can meet in one cycle. The first is the end of a pending transfer. The second is either the arrival of a fresh command or a collision of both outcome inputs. The bench presents a new `cmd_valid` with different arguments while a request is held, then checks that the offset stays put, that no completion appears, and that the later completion reports the original command. It also raises `xfer_done` and `xfer_err` together and expects an error completion. Random commands over random geometries drive every fault path against a bench model that tracks each drive's recorded cylinder.

// File: rtl/sector_xfer_setup.sv
module sector_xfer_setup #(
  parameter int NDRV = 2,
  parameter int OFS_W = 32,
  parameter int LEN_W = 24,
  localparam int DSW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_mt,
  input  logic [DSW-1:0]   arg_drive,
  input  logic [7:0]       arg_cyl,
  input  logic [7:0]       arg_head,
  input  logic [7:0]       arg_sect,
  input  logic [7:0]       arg_size,
  input  logic [7:0]       arg_eot,
  input  logic [7:0]       arg_dtl,
  input  logic [7:0]       geo_cyls,
  input  logic [7:0]       geo_heads,
  input  logic [7:0]       geo_spt,
  input  logic             wr_prot,
  output logic             xfer_req,
  output logic             xfer_write,
  output logic [OFS_W-1:0] xfer_ofs,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_done,
  input  logic             xfer_err,
  output logic             done,
  output logic [55:0]      res_bytes
);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} st_t;
  st_t st;

  logic           l_wr, l_mt, l_prot, seek_f;
  logic [DSW-1:0] l_drv;
  logic [7:0]     l_cyl, l_head, l_sect, l_size, l_eot, l_dtl, l_cyls, l_heads, l_spt;
  logic [7:0]     cyl_pos [NDRV];

  logic [2:0]  code;
  logic [4:0]  shamt;
  logic [9:0]  tgt;
  logic [10:0] span;
  logic        sect_bad, cyl_bad, len_bad, moved, wrap, to_h1;
  logic [LEN_W-1:0] len_val;
  logic [OFS_W-1:0] lba, ofs_val;
  logic [7:0]  nxt_c, nxt_h, nxt_s;

  assign code     = (l_size > 8'd7) ? 3'd7 : l_size[2:0];
  assign shamt    = 5'd7 + 5'(code);
  assign tgt      = l_mt ? {1'b0, l_eot, 1'b0} : {2'b00, l_eot};
  assign span     = {1'b0, tgt} - {3'b000, l_sect} + 11'd1;
  assign len_bad  = (code != 3'd0) && (span[10] || span == 11'd0);
  assign len_val  = (code == 3'd0) ? LEN_W'((l_dtl > 8'd128) ? 8'd128 : l_dtl)
                                   : LEN_W'(span[9:0]) << shamt;
  assign lba      = (OFS_W'(l_cyl) * OFS_W'(l_heads) + OFS_W'(l_head)) * OFS_W'(l_spt)
                    + OFS_W'(l_sect) - OFS_W'(1);
  assign ofs_val  = lba << shamt;
  assign sect_bad = (l_sect == 8'd0) || (l_sect > l_spt);
  assign cyl_bad  = (l_cyl >= l_cyls) || (l_head >= l_heads);
  assign moved    = l_cyl != cyl_pos[l_drv];

  assign wrap  = l_sect >= l_spt;
  assign to_h1 = l_mt && l_head == 8'd0 && l_heads > 8'd1;
  assign nxt_s = wrap ? 8'd1 : l_sect + 8'd1;
  assign nxt_h = !wrap ? l_head : to_h1 ? 8'd1 : l_mt ? 8'd0 : l_head;
  assign nxt_c = (wrap && !to_h1) ? l_cyl + 8'd1 : l_cyl;

  function automatic logic [7:0] mk_st0(input logic abn, input logic sk,
                                        input logic hd, input logic [DSW-1:0] dv);
    return {1'b0, abn, sk, 2'b00, hd, 2'(dv)};
  endfunction

  function automatic logic [55:0] mk_res(input logic [7:0] s0, input logic [7:0] s1,
                                         input logic [7:0] c, input logic [7:0] h,
                                         input logic [7:0] s, input logic [7:0] z);
    return {z, s, h, c, 8'h00, s1, s0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {l_wr, l_mt, l_prot, seek_f} <= '0;
      l_drv <= '0;
      {l_cyl, l_head, l_sect, l_size, l_eot, l_dtl, l_cyls, l_heads, l_spt} <= '0;
      for (int i = 0; i < NDRV; i++) cyl_pos[i] <= '0;
      xfer_req <= 1'b0;
      xfer_write <= 1'b0;
      xfer_ofs <= '0;
      xfer_len <= '0;
      done <= 1'b0;
      res_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          l_wr <= cmd_write;  l_mt <= cmd_mt;     l_prot <= wr_prot;
          l_drv <= arg_drive; l_cyl <= arg_cyl;   l_head <= arg_head;
          l_sect <= arg_sect; l_size <= arg_size; l_eot <= arg_eot;
          l_dtl <= arg_dtl;   l_cyls <= geo_cyls; l_heads <= geo_heads;
          l_spt <= geo_spt;
          st <= S_EVAL;
        end
        S_EVAL: begin
          st <= S_IDLE;
          if (sect_bad) begin
            done <= 1'b1;
            res_bytes <= mk_res(mk_st0(1'b1, 1'b0, l_head[0], l_drv), 8'h00,
                                l_cyl, l_head, l_sect, l_size);
          end else if (cyl_bad) begin
            done <= 1'b1;
            res_bytes <= mk_res(mk_st0(1'b1, 1'b0, l_head[0], l_drv), 8'h80,
                                l_cyl, l_head, l_sect, l_size);
          end else begin
            cyl_pos[l_drv] <= l_cyl;
            seek_f <= moved;
            if (len_bad) begin
              done <= 1'b1;
              res_bytes <= mk_res(mk_st0(1'b1, moved, l_head[0], l_drv), 8'h01,
                                  l_cyl, l_head, l_sect, l_size);
            end else if (l_wr && l_prot) begin
              done <= 1'b1;
              res_bytes <= mk_res(mk_st0(1'b1, 1'b1, l_head[0], l_drv), 8'h02,
                                  l_cyl, l_head, l_sect, l_size);
            end else begin
              xfer_req <= 1'b1;
              xfer_write <= l_wr;
              xfer_ofs <= ofs_val;
              xfer_len <= len_val;
              st <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (xfer_err) begin
            xfer_req <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
            res_bytes <= mk_res(mk_st0(1'b1, seek_f, l_head[0], l_drv), 8'h00,
                                l_cyl, l_head, l_sect, l_size);
          end else if (xfer_done) begin
            xfer_req <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
            res_bytes <= mk_res(mk_st0(1'b0, seek_f, l_head[0], l_drv), 8'h00,
                                nxt_c, nxt_h, nxt_s, l_size);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module sector_xfer_setup_chk #(
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             xfer_req,
  input logic             xfer_done,
  input logic             xfer_err,
  input logic [OFS_W-1:0] xfer_ofs,
  input logic [55:0]      res_bytes
);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done && !xfer_err |=> xfer_req && !done && $stable(xfer_ofs));

  // R12
  req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && (xfer_done || xfer_err) |=> done && !xfer_req);

  // R11
  dma_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_err |=> res_bytes[6] && res_bytes[15:8] == 8'h00);

  // R10
  dma_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done && !xfer_err |=> !res_bytes[6] && res_bytes[23:8] == 16'h0000);

  // R12
  no_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

endmodule

bind sector_xfer_setup sector_xfer_setup_chk #(.OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .xfer_req(xfer_req),
  .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_ofs(xfer_ofs),
  .res_bytes(res_bytes));

// File: tb/test_sector_xfer_setup.sv
module test_sector_xfer_setup;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0, cmd_mt = 0, wr_prot = 0;
  logic [0:0]  arg_drive = '0;
  logic [7:0]  arg_cyl = 0, arg_head = 0, arg_sect = 0, arg_size = 0, arg_eot = 0, arg_dtl = 0;
  logic [7:0]  geo_cyls = 80, geo_heads = 2, geo_spt = 18;
  logic        xfer_done = 0, xfer_err = 0;
  logic        xfer_req, xfer_write, done;
  logic [31:0] xfer_ofs;
  logic [23:0] xfer_len;
  logic [55:0] res_bytes;

  int total = 0, bad = 0;
  int m_cyl [2];

  always #10 clk = ~clk;

  sector_xfer_setup i_sector_xfer_setup (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_mt(cmd_mt), .arg_drive(arg_drive), .arg_cyl(arg_cyl), .arg_head(arg_head),
    .arg_sect(arg_sect), .arg_size(arg_size), .arg_eot(arg_eot), .arg_dtl(arg_dtl),
    .geo_cyls(geo_cyls), .geo_heads(geo_heads), .geo_spt(geo_spt), .wr_prot(wr_prot),
    .xfer_req(xfer_req), .xfer_write(xfer_write), .xfer_ofs(xfer_ofs),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .done(done), .res_bytes(res_bytes));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] pack(input int s0, input int s1, input int c,
                                       input int h, input int s, input int z);
    return {8'(z), 8'(s), 8'(h), 8'(c), 8'h00, 8'(s1), 8'(s0)};
  endfunction

  // oc: 0 = done, 1 = error, 2 = both; intrude: new command while pending
  task automatic run(input bit wr, input bit mt, input int drv, input int c, input int h,
                     input int s, input int sz, input int eot, input int dtl,
                     input bit prot, input int oc, input bit intrude);
    int cyls, heads, spt, code, ssz, n, len, ofs, hb, mv, nc, nh, ns;
    logic [55:0] er;
    string tag;
    bit fault;
    cyls = int'(geo_cyls); heads = int'(geo_heads); spt = int'(geo_spt);
    code = (sz > 7) ? 7 : sz;
    ssz = 128 << code;
    hb = (h & 1) << 2;
    fault = 1; mv = 0; len = 0; ofs = 0;
    if (s == 0 || s > spt) begin
      tag = "R2"; er = pack(8'h40 | hb | drv, 0, c, h, s, sz);
    end else if (c >= cyls || h >= heads) begin
      tag = "R3"; er = pack(8'h40 | hb | drv, 8'h80, c, h, s, sz);
    end else begin
      mv = (c != m_cyl[drv]) ? 8'h20 : 0;
      m_cyl[drv] = c;
      n = (mt ? 2 * eot : eot) - s + 1;
      if (code == 0) len = (dtl > 128) ? 128 : dtl;
      else len = n * ssz;
      if (code != 0 && n <= 0) begin
        tag = "R6"; er = pack(8'h40 | mv | hb | drv, 8'h01, c, h, s, sz);
      end else if (wr && prot) begin
        tag = "R7"; er = pack(8'h60 | hb | drv, 8'h02, c, h, s, sz);
      end else begin
        fault = 0;
        ofs = ((c * heads + h) * spt + s - 1) * ssz;
      end
    end
    @(negedge clk);
    cmd_write = wr; cmd_mt = mt; arg_drive = 1'(drv); arg_cyl = 8'(c); arg_head = 8'(h);
    arg_sect = 8'(s); arg_size = 8'(sz); arg_eot = 8'(eot); arg_dtl = 8'(dtl); wr_prot = prot;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(done == 0 && xfer_req == 0, "R12 idle eval", {done, xfer_req}, 0);
    @(negedge clk);
    if (fault) begin
      chk(done == 1 && xfer_req == 0, {tag, " error done"}, {done, xfer_req}, 2);
      chk(res_bytes == er, {tag, " result"}, res_bytes, er);
      return;
    end
    chk(xfer_req == 1 && done == 0, "R12 request", {xfer_req, done}, 2);
    chk(xfer_ofs == 32'(ofs), "R8 offset", xfer_ofs, ofs);
    chk(xfer_len == 24'(len), code == 0 ? "R4 length" : "R5 length", xfer_len, len);
    chk(xfer_write == wr, "R7 direction", xfer_write, wr);
    if (intrude) begin
      arg_cyl = 8'(c + 1); arg_sect = 8'd1; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
      chk(xfer_req == 1 && done == 0 && xfer_ofs == 32'(ofs), "R12 ignore cmd",
          {xfer_req, done, xfer_ofs}, {2'b10, 32'(ofs)});
    end
    xfer_done = (oc != 1); xfer_err = (oc != 0);
    @(negedge clk);
    xfer_done = 0; xfer_err = 0;
    chk(done == 1 && xfer_req == 0, "R12 outcome done", {done, xfer_req}, 2);
    if (oc != 0) begin
      er = pack(8'h40 | mv | hb | drv, 0, c, h, s, sz);
      chk(res_bytes == er, "R11 dma error result", res_bytes, er);
    end else begin
      ns = s + 1; nh = h; nc = c;
      if (s >= spt) begin
        ns = 1;
        if (mt && h == 0 && heads > 1) nh = 1;
        else begin nc = (c + 1) & 255; if (mt) nh = 0; end
      end
      er = pack(mv | hb | drv, 0, nc, nh, ns, sz);
      chk(res_bytes == er, mv != 0 ? "R9 R10 success result" : "R10 success result", res_bytes, er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cyl[0] = 0; m_cyl[1] = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && xfer_req == 0 && res_bytes == 0, "R1 reset", {done, xfer_req, res_bytes}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && xfer_req == 0 && res_bytes == 0, "R1 after reset", {done, xfer_req, res_bytes}, 0);

    run(0, 0, 0, 0, 0, 1, 2, 18, 0, 0, 0, 0);     // R1 cylinder 0, no seek bit; R5
    run(0, 0, 0, 5, 1, 3, 2, 18, 0, 0, 0, 0);     // R9 moved
    run(0, 0, 0, 5, 1, 4, 2, 18, 0, 0, 0, 0);     // R9 not moved
    run(0, 0, 1, 7, 0, 2, 0, 18, 200, 0, 0, 0);   // R4 capped
    run(0, 0, 1, 7, 0, 2, 0, 18, 60, 0, 0, 0);    // R4 short
    run(0, 1, 0, 3, 0, 5, 2, 18, 0, 0, 0, 0);     // R5 multi-track
    run(0, 0, 0, 3, 0, 5, 9, 5, 0, 0, 0, 0);      // R5 clamp to 16384
    run(0, 0, 0, 3, 0, 10, 2, 3, 0, 0, 0, 0);     // R6 negative
    run(0, 0, 0, 4, 0, 4, 1, 3, 0, 0, 0, 0);      // R6 zero, with seek bit
    run(0, 0, 0, 4, 0, 0, 2, 18, 0, 0, 0, 0);     // R2 sector 0
    run(0, 0, 0, 4, 0, 19, 2, 18, 0, 0, 0, 0);    // R2 sector high
    run(0, 0, 0, 90, 3, 19, 2, 18, 0, 0, 0, 0);   // R2 priority over R3
    run(0, 0, 0, 80, 0, 1, 2, 18, 0, 0, 0, 0);    // R3 cylinder
    run(0, 0, 0, 6, 2, 1, 2, 18, 0, 0, 0, 0);     // R3 head
    run(1, 0, 1, 7, 1, 1, 2, 18, 0, 1, 0, 0);     // R7 protected
    run(0, 0, 1, 7, 1, 1, 2, 18, 0, 1, 0, 0);     // R7 read ignores protect
    run(1, 0, 1, 7, 1, 2, 2, 18, 0, 0, 1, 0);     // R11 dma error
    run(0, 0, 1, 8, 0, 2, 2, 18, 0, 0, 2, 0);     // R11 both outcomes
    run(0, 1, 0, 9, 0, 18, 2, 18, 0, 0, 0, 0);    // R10 wrap to head 1
    run(0, 1, 0, 9, 1, 18, 2, 36, 0, 0, 0, 0);    // R10 wrap to next cylinder
    run(0, 0, 0, 9, 1, 18, 2, 18, 0, 0, 0, 0);    // R10 wrap without multi-track
    run(0, 0, 0, 9, 1, 3, 2, 18, 0, 0, 0, 1);     // R12 command while pending

    @(negedge clk); xfer_done = 1; xfer_err = 1;  // R12 outcome while idle
    @(negedge clk); xfer_done = 0; xfer_err = 0;
    chk(done == 0 && xfer_req == 0, "R12 idle outcome ignored", {done, xfer_req}, 0);
    @(negedge clk);
    chk(done == 0, "R12 idle outcome ignored later", done, 0);

    for (int k = 0; k < 400; k++) begin
      geo_cyls  = 8'($urandom_range(1, 100));
      geo_heads = 8'($urandom_range(1, 2));
      geo_spt   = 8'($urandom_range(1, 36));
      run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 1),
          $urandom_range(0, int'(geo_cyls) + 2), $urandom_range(0, 2),
          $urandom_range(0, int'(geo_spt) + 2), $urandom_range(0, 9),
          $urandom_range(0, 40), $urandom_range(0, 255),
          1'($urandom_range(0, 3) == 0), $urandom_range(0, 2), 1'($urandom_range(0, 7) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule